// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This controller gathers up to 32 interrupt sources onto one normal request output and serves a single dedicated fast request output. The low-numbered sources are external request pins with a selectable trigger (high or low level, rising or falling edge). The rest are on-chip lines that are either level-sensitive or rising-edge triggered. Each source has an enable bit, a 3-bit priority and a vector word. The controller offers the vector of the best pending enabled source.

Nesting is tracked in hardware with eight priority levels. A vector read acknowledges the winning source and records its level as in service. From then on only a strictly higher level can raise the normal request again. An end-of-interrupt write retires the highest level in service. The fast output is reserved for the fast input and is never driven by any normal source.

All inputs pass through a two-flop synchronizer. Software reaches the registers through a simple single-cycle read/write port.

Top module: `prio_vector_irq`

## Requirements
- R1: After reset no level is in service, `irq_o` and `fiq_o` are low, and every source is disabled with priority 0, trigger code 01 and vector 0. A read of the pending word at address 0x50 then returns 0 while all inputs are low.
- R2: Each source has a configuration word at address 0x00+n: bits [2:0] hold the priority, bits [4:3] the trigger code and bit 5 the enable. A disabled source never raises `irq_o`, but its raw pending bit still shows at address 0x50.
- R3: Among pending enabled sources the highest priority wins. On equal priority the lowest source number wins. Reading address 0x40 returns the winner's vector, which is written at address 0x20+n.
- R4: A read of 0x40 while `irq_o` is high acknowledges the winner and marks its level as in service. `irq_o` then stays low while no pending source sits above that level.
- R5: `irq_o` is high only when the winner's priority is strictly above the highest level in service, or when nothing is in service. Equal or lower levels wait.
- R6: A write to address 0x44 (end of interrupt) retires the highest level in service. With nothing in service it has no effect. The in-service set changes only on an acknowledge or an end of interrupt.
- R7: An external source decodes trigger codes as 00 low level, 01 high level, 10 falling edge and 11 rising edge.
- R8: An internal source is rising-edge triggered when trigger bit 1 is set, and high-level otherwise. Trigger bit 0 is ignored.
- R9: An edge-triggered source stays pending after its input returns, until its own acknowledge clears the latch.
- R10: `fiq_o` follows only `fast_in`. Its configuration at address 0x48 holds the trigger code in bits [1:0] (same codes as R7) and the enable in bit 2. A write to 0x4C clears the fast edge latch.
- R11: A read of 0x40 while `irq_o` is low returns the spurious vector (default 0xFFFF) and leaves the in-service set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NSRC | Interrupt source lines; the lowest NEXT are external |
| fast_in | input | 1 | Dedicated fast interrupt input |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used for vector acknowledge) |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
On every cycle the assertions check the nesting bookkeeping:
- an acknowledge adds exactly one level to the in-service set;
- an end of interrupt removes exactly one level;
- the set holds still otherwise;
- the top level blocks all requests;
- a read with no request yields the spurious vector.

The arbitration order, the four external trigger decodes, the internal edge mode, the latch held after an edge, the mask, and the fast path are shown only by the bench's scenarios, which watch the request outputs and read back vectors and pending bits.

// File: rtl/prio_vector_irq.sv
module prio_vector_irq #(
  parameter int NSRC  = 8,
  parameter int NEXT  = 4,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] SPUR = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic             fast_in,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [6:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] s1, s2, s3, latch, edge_now, pend, ack_mask;
  logic [2:0]      prio [NSRC];
  logic [1:0]      trig [NSRC];
  logic [VEC_W-1:0] vec [NSRC];
  logic [NSRC-1:0] en;
  logic [7:0]      isr;
  logic            f1, f2, f3, flatch;
  logic [2:0]      fcfg;

  logic [IW-1:0]   win_idx;
  logic [2:0]      win_prio, top_lvl;
  logic            win_valid;

  wire ack  = bus_rd && bus_addr == 7'h40 && irq_o;
  wire eoi  = bus_wr && bus_addr == 7'h44;
  wire fclr = bus_wr && bus_addr == 7'h4C;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3, f1, f2, f3} <= '0;
    else begin
      s1 <= src_in; s2 <= s1; s3 <= s2;
      f1 <= fast_in; f2 <= f1; f3 <= f2;
    end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    wire pol  = (i < NEXT) ? trig[i][0] : 1'b1;
    wire emod = trig[i][1];
    assign edge_now[i] = emod & (pol ? (s2[i] & ~s3[i]) : (~s2[i] & s3[i]));
    assign pend[i]     = emod ? latch[i] : (s2[i] == pol);
    assign ack_mask[i] = ack && win_idx == IW'(i);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        prio[i] <= '0; trig[i] <= 2'b01; en[i] <= 1'b0; vec[i] <= '0; latch[i] <= 1'b0;
      end else begin
        if (bus_wr && bus_addr == 7'(i))
          {en[i], trig[i], prio[i]} <= bus_wdata[5:0];
        if (bus_wr && bus_addr == 7'(32 + i))
          vec[i] <= bus_wdata[VEC_W-1:0];
        latch[i] <= (latch[i] & ~ack_mask[i]) | edge_now[i];
      end
  end

  always_comb begin
    win_valid = 1'b0; win_idx = '0; win_prio = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && en[i] && (!win_valid || prio[i] > win_prio)) begin
        win_valid = 1'b1; win_idx = IW'(i); win_prio = prio[i];
      end
    top_lvl = '0;
    for (int l = 0; l < 8; l++)
      if (isr[l]) top_lvl = 3'(l);
  end

  assign irq_o = win_valid && (isr == '0 || win_prio > top_lvl);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) isr <= '0;
    else if (ack) isr <= isr | (8'd1 << win_prio);
    else if (eoi && isr != '0) isr <= isr & ~(8'd1 << top_lvl);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fcfg <= '0; flatch <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == 7'h48) fcfg <= bus_wdata[2:0];
      flatch <= (flatch & ~fclr) | (fcfg[1] & (fcfg[0] ? (f2 & ~f3) : (~f2 & f3)));
    end

  assign fiq_o = fcfg[2] & (fcfg[1] ? flatch : (f2 == fcfg[0]));

  always_comb
    case (bus_addr)
      7'h40:   bus_rdata = irq_o ? 32'(vec[win_idx]) : 32'(SPUR);
      7'h50:   bus_rdata = 32'(pend);
      default: bus_rdata = '0;
    endcase

  p_ack_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> $countones(isr) == $countones($past(isr)) + 1);
  p_eoi_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && isr != '0) |=> $countones(isr) + 1 == $countones($past(isr)));
  p_isr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !eoi) |=> $stable(isr));
  p_top_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    isr[7] |-> !irq_o);
  p_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 7'h40 && !irq_o) |-> bus_rdata == 32'(SPUR));
endmodule

// File: tb/prio_vector_irq_test.sv
module prio_vector_irq_test;
  logic clk = 0, rst_n = 0, fast_in = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] src_in = 0;
  logic [6:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, v;
  logic irq_o, fiq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_vector_irq uut (.clk, .rst_n, .src_in, .fast_in, .bus_wr, .bus_rd,
    .bus_addr, .bus_wdata, .bus_rdata(), .irq_o, .fiq_o);
  wire [31:0] rdata = uut.bus_rdata;

  // {inputs, expected irq, expected vector}
  localparam logic [24:0] TBL [8] = '{
    {8'h00, 1'b0, 16'hFFFF}, {8'h01, 1'b1, 16'hA000},
    {8'h06, 1'b1, 16'hA001}, {8'h18, 1'b1, 16'hA003},
    {8'h40, 1'b0, 16'hFFFF}, {8'hE1, 1'b1, 16'hA005},
    {8'hFF, 1'b1, 16'hA003}, {8'h81, 1'b1, 16'hA007}};
  localparam logic [5:0] CFG [8] = '{6'h29, 6'h2C, 6'h2C, 6'h2E, 6'h2E, 6'h2B, 6'h0F, 6'h2A};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    chk("R1 irq", irq_o, 0);
    chk("R1 fiq", fiq_o, 0);
    rd(7'h40, v); chk("R1 vector", v, 32'hFFFF);
    rd(7'h50, v); chk("R1 pending", v, 0);

    for (int i = 0; i < 8; i++) begin
      wr(7'(i), 32'(CFG[i]));
      wr(7'(32 + i), 32'hA000 + i);
    end

    for (int r = 0; r < 8; r++) begin
      src_in = TBL[r][24:17];
      settle();
      chk("R3/R2 irq", irq_o, TBL[r][16]);
      chk("R10 fiq idle", fiq_o, 0);
      rd(7'h40, v); chk("R3/R11 vector", v, 32'(TBL[r][15:0]));
      wr(7'h44, 0);
    end

    // R5 preemption and R6 retire order
    src_in = 8'h02; settle();
    rd(7'h40, v); chk("R4 ack vector", v, 32'hA001);
    settle(); chk("R4 irq drops", irq_o, 0);
    src_in = 8'h0A; settle();
    chk("R5 higher preempts", irq_o, 1);
    rd(7'h40, v); chk("R5 vector", v, 32'hA003);
    src_in = 8'h06; settle();
    chk("R5 equal waits", irq_o, 0);
    wr(7'h44, 0); settle();
    chk("R6 pop to 4", irq_o, 0);
    wr(7'h44, 0); settle();
    chk("R6 pop to empty", irq_o, 1);
    rd(7'h40, v); chk("R6 vector", v, 32'hA001);
    wr(7'h44, 0);
    src_in = 0; settle();

    // R7 rising edge on external source 0, R9 latch
    wr(7'h00, 32'h39);
    src_in[0] = 1; repeat (2) @(negedge clk); src_in[0] = 0; settle();
    chk("R7 rising irq", irq_o, 1);
    rd(7'h50, v); chk("R9 latch held", v[0], 1);
    rd(7'h40, v); chk("R7 rising vector", v, 32'hA000);
    settle(); rd(7'h50, v); chk("R9 latch cleared", v[0], 0);
    wr(7'h44, 0);

    // R7 falling edge on source 1
    wr(7'h01, 32'h34);
    src_in[1] = 1; settle();
    chk("R7 falling ignores rise", irq_o, 0);
    src_in[1] = 0; settle();
    chk("R7 falling irq", irq_o, 1);
    rd(7'h40, v); chk("R7 falling vector", v, 32'hA001);
    wr(7'h44, 0);

    // R7 low level on source 2
    wr(7'h02, 32'h24); settle();
    chk("R7 low level irq", irq_o, 1);
    rd(7'h40, v); chk("R7 low level vector", v, 32'hA002);
    src_in[2] = 1;
    wr(7'h44, 0); settle();
    chk("R7 high input idle", irq_o, 0);

    // R8 internal rising edge on source 4
    wr(7'h04, 32'h36);
    src_in[4] = 1; repeat (2) @(negedge clk); src_in[4] = 0; settle();
    chk("R8 internal edge irq", irq_o, 1);
    rd(7'h40, v); chk("R8 vector", v, 32'hA004);
    settle(); rd(7'h50, v); chk("R8 latch cleared", v[4], 0);
    wr(7'h44, 0);

    // R2 masked source still visible as pending
    src_in[6] = 1; settle();
    chk("R2 masked irq", irq_o, 0);
    rd(7'h50, v); chk("R2 raw pending", v[6], 1);
    src_in[6] = 0;

    // R10 fast path
    fast_in = 1; settle();
    chk("R10 fast disabled", fiq_o, 0);
    wr(7'h48, 32'h5); settle();
    chk("R10 fast level", fiq_o, 1);
    chk("R10 irq unaffected", irq_o, 0);
    fast_in = 0; settle();
    chk("R10 fast level low", fiq_o, 0);
    wr(7'h48, 32'h7);
    fast_in = 1; settle(); fast_in = 0; settle();
    chk("R10 fast edge held", fiq_o, 1);
    wr(7'h4C, 0); settle();
    chk("R10 fast cleared", fiq_o, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule